// File: doc/BRIEF.md
# Pipelined Adaptive FIR Filter with Delayed Coefficient Update

This block is a direct-form adaptive FIR filter. Each accepted sample pair (input `x_in`, target `d_in`) moves one step through a pipelined datapath. The stages are a registered multiplier per tap, a registered binary adder tree, and a registered output and error stage. The coefficients adapt by a least-mean-squares rule. The rule uses an error and an input vector that are `M` samples old, so the multiply-add loop that feeds the coefficients back is broken by pipeline registers rather than being one long combinational path.

The latency `M` is set by the structure: one product stage, `clog2(N)` adder levels and one error stage, so `M = clog2(N) + 2`. The old input vector is read from the far end of a tap line `N + M` deep, so no separate buffer holds it. The step size is a power of two, set as an extra right shift. The pipeline advances only on `in_valid`, so idle cycles between samples change nothing.

A typical use is system identification or echo cancellation. The reference signal drives `x_in`, the observed signal drives `d_in`, and `e_out` carries the residual.

Top module: `dlms_filter`

## Requirements
- R1: A synchronous active-high `rst` clears every register. In the cycle after reset `out_valid`, `y_out` and `e_out` are 0. All coefficients start at zero, so `y_out` stays 0 while the input is non-zero until a non-zero error has been fed back.
- R2: For sample n (counting from 0 after reset, with x(k)=0 for k<0), `y_out` = clamp(round(sum over i<N of w_i(n)·x(n−i) / 2^WFRAC), DW bits). Coefficients are two's complement with WFRAC fraction bits. Rounding is half-up: add 2^(s−1), then shift right arithmetically by s.
- R3: `e_out` for sample n = clamp(d(n) − y(n), DW bits), using the clamped y(n). For example, d = −32768 with y = 32767 yields −32768.
- R4: y(n) and e(n) appear on the clock after the edge that accepts sample n+M, where M = clog2(N)+2 (4 at N=4). The first M accepted samples after reset produce no `out_valid`.
- R5: The coefficient update is w_i(n+1) = clamp(w_i(n) + clamp(round(e(n−M)·x(n−M−i) / 2^S), WW), WW). Here S = MU_SHIFT + 2·(DW−1) − WFRAC, and e(k)=x(k)=0 for k<0.
- R6: Cycles with `in_valid` low leave `y_out`, `e_out` and all coefficients unchanged, and they do not alter any later result.
- R7: Once the pipeline is full, `out_valid` is high for exactly the one cycle after each accepted sample, and low after every idle cycle.
- R8: When the filter identifies a fixed 4-tap system driven by full-band random input, the mean of `e_out`² over the last 512 samples of a 4000-sample run is below 16.
- R9: When the target is held at full scale, `y_out` saturates at 32767 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts one sample pair and advances the pipeline |
| x_in | input | DW | Signed input sample |
| d_in | input | DW | Signed desired (target) sample |
| out_valid | output | 1 | Marks a new result on `y_out` and `e_out` |
| y_out | output | DW | Filter output, delayed by M samples |
| e_out | output | DW | Error, target minus output, delayed by M samples |

## Verification
The hardest state to reach from the ports is a coefficient pressed against its clamp limit. A well-behaved identification run never leaves the small-weight region.

The stimulus therefore adds a phase with a full-scale constant target and input, followed by a phase in which the target is held at the opposite rail. A last phase pairs alternating full-scale input with a constant target that no coefficient set can match. Together these drive the output, the error and the update terms into clamping.

Every output is compared against a sample-indexed model of the requirements. That model also checks that random idle gaps leave the arithmetic untouched.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

  typedef logic signed [63:0] wide_t;

  // Arithmetic right shift with round-half-up; sh == 0 passes through.
  function automatic wide_t round_shift(input wide_t v, input int unsigned sh);
    wide_t half;
    if (sh == 0) return v;
    half = wide_t'(64'sd1) <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Clamp a wide value into the signed range of a 'bits'-bit word.
  function automatic wide_t clamp(input wide_t v, input int unsigned bits);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(64'sd1) <<< (bits - 1)) - wide_t'(64'sd1);
    lo = -(wide_t'(64'sd1) <<< (bits - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/dlms_tapline.sv
module dlms_tapline #(
  parameter int DW  = 16,
  parameter int LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] taps [LEN]
);

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)     taps[i] <= '0;
        else if (en) taps[i] <= x_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)     taps[i] <= '0;
        else if (en) taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/dlms_fir.sv
module dlms_fir #(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int WW   = 24,
  parameter int ACCW = DW + WW + $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [DW-1:0]   x [N],
  input  logic signed [WW-1:0]   w [N],
  output logic signed [ACCW-1:0] sum
);

  localparam int LVL = $clog2(N);
  localparam int NP  = 1 << LVL;
  localparam int PW  = DW + WW;

  // Heap-indexed tree: leaves NP..2NP-1 hold products, node 1 is the root.
  logic signed [ACCW-1:0] node [1:2*NP-1];

  for (genvar k = NP; k < 2*NP; k++) begin : g_leaf
    if (k - NP < N) begin : g_mul
      logic signed [PW-1:0] prod;
      assign prod = x[k-NP] * w[k-NP];
      always_ff @(posedge clk) begin
        if (rst)     node[k] <= '0;
        else if (en) node[k] <= ACCW'(prod);
      end
    end else begin : g_pad
      always_ff @(posedge clk) node[k] <= '0;
    end
  end

  for (genvar k = 1; k < NP; k++) begin : g_add
    always_ff @(posedge clk) begin
      if (rst)     node[k] <= '0;
      else if (en) node[k] <= node[2*k] + node[2*k+1];
    end
  end

  assign sum = node[1];

endmodule

// File: rtl/dlms_update.sv
module dlms_update #(
  parameter int          N  = 4,
  parameter int          DW = 16,
  parameter int          WW = 24,
  parameter int unsigned SH = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] err,
  input  logic signed [DW-1:0] x_old [N],
  output logic signed [WW-1:0] w [N]
);
  import dlms_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_coef
    logic signed [2*DW-1:0] prod;
    wide_t                  step;

    assign prod = err * x_old[i];

    always_comb begin
      step = clamp(round_shift(wide_t'(prod), SH), WW);
    end

    always_ff @(posedge clk) begin
      if (rst)     w[i] <= '0;
      else if (en) w[i] <= WW'(clamp(wide_t'(w[i]) + step, WW));
    end
  end

endmodule

// File: rtl/dlms_errstage.sv
module dlms_errstage #(
  parameter int          DW    = 16,
  parameter int          ACCW  = 42,
  parameter int unsigned WFRAC = 22,
  parameter int          M     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [DW-1:0]   d_in,
  input  logic signed [ACCW-1:0] sum,
  output logic                   out_valid,
  output logic signed [DW-1:0]   y_out,
  output logic signed [DW-1:0]   e_out
);
  import dlms_pkg::*;

  localparam int CW = $clog2(M + 1);

  logic signed [DW-1:0] dd [M];
  logic [CW-1:0]        fill_q;
  wide_t                y_w;

  // Target delay line aligned to the datapath latency.
  for (genvar j = 0; j < M; j++) begin : g_dline
    if (j == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)     dd[j] <= '0;
        else if (en) dd[j] <= d_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)     dd[j] <= '0;
        else if (en) dd[j] <= dd[j-1];
      end
    end
  end

  always_comb begin
    y_w = clamp(round_shift(wide_t'(sum), WFRAC), DW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
      y_out     <= '0;
      e_out     <= '0;
    end else begin
      out_valid <= en && (fill_q == CW'(M));
      if (en) begin
        if (fill_q != CW'(M)) fill_q <= fill_q + 1'b1;
        y_out <= DW'(y_w);
        e_out <= DW'(clamp(wide_t'(dd[M-1]) - y_w, DW));
      end
    end
  end

endmodule

// File: rtl/dlms_filter.sv
module dlms_filter #(
  parameter int N        = 4,
  parameter int DW       = 16,
  parameter int WW       = 24,
  parameter int WFRAC    = 22,
  parameter int MU_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] d_in,
  output logic                 out_valid,
  output logic signed [DW-1:0] y_out,
  output logic signed [DW-1:0] e_out
);

  localparam int LVL       = $clog2(N);
  localparam int M         = LVL + 2;
  localparam int ACCW      = DW + WW + LVL;
  localparam int TAPS      = N + M;
  localparam int UPD_SHIFT = MU_SHIFT + 2 * (DW - 1) - WFRAC;

  logic signed [DW-1:0]   taps  [TAPS];
  logic signed [DW-1:0]   x_now [N];
  logic signed [DW-1:0]   x_old [N];
  logic signed [WW-1:0]   w_q   [N];
  logic signed [ACCW-1:0] acc;

  for (genvar i = 0; i < N; i++) begin : g_view
    assign x_now[i] = taps[i];
    assign x_old[i] = taps[M + i];
  end

  dlms_tapline #(.DW(DW), .LEN(TAPS)) u_taps (
    .clk  (clk),
    .rst  (rst),
    .en   (in_valid),
    .x_in (x_in),
    .taps (taps)
  );

  dlms_fir #(.N(N), .DW(DW), .WW(WW), .ACCW(ACCW)) u_fir (
    .clk (clk),
    .rst (rst),
    .en  (in_valid),
    .x   (x_now),
    .w   (w_q),
    .sum (acc)
  );

  dlms_errstage #(.DW(DW), .ACCW(ACCW), .WFRAC(WFRAC), .M(M)) u_err (
    .clk       (clk),
    .rst       (rst),
    .en        (in_valid),
    .d_in      (d_in),
    .sum       (acc),
    .out_valid (out_valid),
    .y_out     (y_out),
    .e_out     (e_out)
  );

  dlms_update #(.N(N), .DW(DW), .WW(WW), .SH(UPD_SHIFT)) u_upd (
    .clk   (clk),
    .rst   (rst),
    .en    (in_valid),
    .err   (e_out),
    .x_old (x_old),
    .w     (w_q)
  );

endmodule

// File: rtl/dlms_filter_chk.sv
module dlms_filter_chk #(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int WW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] y_out,
  input logic signed [DW-1:0] e_out,
  input logic signed [WW-1:0] w [N]
);

  localparam int M  = $clog2(N) + 2;
  localparam int CW = $clog2(M + 2);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)                                seen_q <= '0;
    else if (in_valid && seen_q != CW'(M+1)) seen_q <= seen_q + 1'b1;
  end

  // R4: no result before M+1 samples have entered
  p_no_early_valid_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q == CW'(M+1)));

  // R7: a result only follows an accepted sample
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R7: idle cycle yields no result
  p_idle_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: outputs hold across idle cycles
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(y_out) && $stable(e_out)));

  // R6: coefficients frozen across idle cycles
  for (genvar i = 0; i < N; i++) begin : g_wchk
    p_coef_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(w[i]));
  end

endmodule

bind dlms_filter dlms_filter_chk #(.N(N), .DW(DW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .y_out     (y_out),
  .e_out     (e_out),
  .w         (w_q)
);

// File: tb/dlms_filter_bench.sv
module dlms_filter_bench;

  localparam int CLK_P    = 10;
  localparam int N        = 4;
  localparam int DW       = 16;
  localparam int WW       = 24;
  localparam int WFRAC    = 22;
  localparam int MU_SHIFT = 4;
  localparam int M        = $clog2(N) + 2;
  localparam int SH       = MU_SHIFT + 2 * (DW - 1) - WFRAC;
  localparam int NS       = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic signed [DW-1:0] d_in = '0;
  logic out_valid;
  logic signed [DW-1:0] y_out;
  logic signed [DW-1:0] e_out;

  always #(CLK_P/2) clk = ~clk;

  dlms_filter #(.N(N), .DW(DW), .WW(WW), .WFRAC(WFRAC), .MU_SHIFT(MU_SHIFT)) u_dlms_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .out_valid(out_valid), .y_out(y_out), .e_out(e_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  longint wm [N];
  longint xh [NS];
  longint yh [NS];
  longint eh [NS];
  int     ns;
  longint hsys [N];
  longint y_max_seen;
  longint e_min_seen;
  longint sq_sum;
  int     sq_cnt;
  bit     collect;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rsh(input longint v, input int s);
    if (s == 0) return v;
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  function automatic longint sat(input longint v, input int bits);
    longint hi = (longint'(1) <<< (bits - 1)) - 1;
    longint lo = -(longint'(1) <<< (bits - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint xat(input int k);
    return (k < 0) ? 0 : xh[k];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) wm[i] = 0;
    ns = 0;
  endtask

  task automatic model_step(input longint xv, input longint dv);
    longint acc = 0;
    xh[ns] = xv;
    for (int i = 0; i < N; i++) acc += wm[i] * xat(ns - i);
    yh[ns] = sat(rsh(acc, WFRAC), DW);
    eh[ns] = sat(dv - yh[ns], DW);
    if (ns >= M)
      for (int i = 0; i < N; i++)
        wm[i] = sat(wm[i] + sat(rsh(eh[ns-M] * xat(ns - M - i), SH), WW), WW);
    ns++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(y_out == 0, "R1 y_out", longint'(y_out), 0);
    chk(e_out == 0, "R1 e_out", longint'(e_out), 0);
  endtask

  // One accepted sample, then 'idle' empty cycles.
  task automatic push(input longint xv, input longint dv, input int idle);
    int idx;
    logic signed [DW-1:0] y_hold;
    logic signed [DW-1:0] e_hold;
    model_step(xv, dv);
    idx = ns - 1;
    x_in = DW'(xv); d_in = DW'(dv); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (idx >= M) begin
      chk(out_valid == 1'b1, "R7 valid after sample", longint'(out_valid), 1);
      chk(longint'(y_out) == yh[idx-M], "R2 R4 y_out", longint'(y_out), yh[idx-M]);
      chk(longint'(e_out) == eh[idx-M], "R3 R4 e_out", longint'(e_out), eh[idx-M]);
      if (longint'(y_out) > y_max_seen) y_max_seen = longint'(y_out);
      if (longint'(e_out) < e_min_seen) e_min_seen = longint'(e_out);
      if (collect) begin
        sq_sum += longint'(e_out) * longint'(e_out);
        sq_cnt++;
      end
    end else begin
      chk(out_valid == 1'b0, "R4 no valid during fill", longint'(out_valid), 0);
    end
    y_hold = y_out; e_hold = e_out;
    for (int c = 0; c < idle; c++) begin
      x_in = DW'($urandom); d_in = DW'($urandom);
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle no valid", longint'(out_valid), 0);
      chk(y_out == y_hold && e_out == e_hold, "R6 idle hold", longint'(y_out), longint'(y_hold));
    end
  endtask

  function automatic longint sys_out(input int k);
    longint acc = 0;
    for (int i = 0; i < N; i++) acc += hsys[i] * xat(k - i);
    return sat(rsh(acc, WFRAC), DW);
  endfunction

  initial begin
    void'($urandom(32'd4242));
    hsys[0] = 2097152; hsys[1] = -1048576; hsys[2] = 524288; hsys[3] = 262144;
    y_max_seen = -100000; e_min_seen = 100000;
    sq_sum = 0; sq_cnt = 0; collect = 0;

    // R1 reset state, then zero coefficients give zero output
    do_reset();
    for (int k = 0; k < M + N + 2; k++) push(longint'(12000 - 3000 * k), 0, 0);
    chk(y_out == 0, "R1 zero coefficients", longint'(y_out), 0);

    // Identification with random idle gaps (R2 R3 R4 R5 R6 R8)
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      longint xv = longint'($urandom % 32001) - 16000;
      int idle = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
      xh[ns] = xv;
      collect = (k >= 4000 - 512);
      push(xv, sys_out(ns), idle);
    end
    collect = 0;
    chk(sq_cnt == 512, "R8 sample count", sq_cnt, 512);
    chk(sq_sum < 16 * 512, "R8 mean squared error", sq_sum / 512, 16);

    // Saturation corners (R9 R3 R5)
    do_reset();
    y_max_seen = -100000; e_min_seen = 100000;
    for (int k = 0; k < 40; k++) push(32767, 32767, 0);
    chk(y_max_seen == 32767, "R9 y clamps at 32767", y_max_seen, 32767);
    for (int k = 0; k < 40; k++) push(32767, -32768, k % 2);
    chk(e_min_seen == -32768, "R3 e clamps at -32768", e_min_seen, -32768);
    for (int k = 0; k < 200; k++) push((k % 2 == 0) ? 32767 : -32768, 32767, 0);
    push(0, 0, 3);

    n_chk++;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule